// File: doc/BRIEF.md
# Serial Register Access Port

This block is the device side of a four-wire serial port: a select line, a serial clock, a data input and a data output. Through it a host writes and reads a small bank of byte-wide control registers, and it reads a 24-bit conversion result. Every frame opens with the select line driven low. The host then sends a leading zero, a three-bit address and a direction bit. A write frame carries one more byte. A read frame returns either a byte or a 24-bit word, and the address picks which of the two.

While no frame is open, the data output doubles as an active-low conversion-complete flag. The converter side hands results in over a valid/ready stream. Ready is held high at all times, so there is no back-pressure. The newest result always overwrites the one before it, and every accepted result raises the flag.

All serial inputs pass through synchronizers into the system clock domain. The block samples them on detected serial-clock edges.

Top module: `ser_reg_port`

## Requirements
- R1: After reset every control register reads zero, no result is pending, and the idle data output is high.
- R2: A frame header is sampled on rising serial-clock edges. It is a leading 0, then address bits A2, A1, A0 (most significant first), then a direction bit where 0 means write and 1 means read.
- R3: A write with A2=0 stores its eight data bits, sent most significant first, into control register A1:A0 once the eighth data bit is sampled. Register k appears on `ctrl_regs[8k+7:8k]`.
- R4: A read with A2=0 returns the addressed control byte, most significant first. The output changes on falling serial-clock edges, and the first bit is driven after the falling edge that follows the direction bit.
- R5: A read with A2=1 returns the 24-bit conversion result, most significant first, with the same timing as R4.
- R6: Raising the select line ends any frame and clears the bit position. A write cut short leaves every register unchanged, and the next frame decodes normally.
- R7: A frame whose leading bit is 1 has no effect.
- R8: A write with A2=1 changes no register.
- R9: An accepted result (`res_valid` high) makes the idle data output go low.
- R10: Starting a read with A2=1 clears the pending flag, unless a new result arrives in that cycle. Reading a control register does not clear it.
- R11: The result word is captured when a read with A2=1 starts. A result accepted while that word is being shifted out does not change the word, but it does become pending.
- R12: `res_ready` is always high, and a read with A2=1 returns the most recently accepted result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial read data; active-low conversion flag when not selected |
| res_valid | input | 1 | Conversion result valid |
| res_ready | output | 1 | Result accept, held high |
| res_data | input | 24 | Conversion result word |
| ctrl_regs | output | 32 | Control registers packed, register k at bits 8k+7:8k |

## Verification
The hardest case to reach from the ports is a conversion landing in the middle of a result read. It must leave the outgoing word intact and still leave the flag set once the frame closes. The bench reaches this from inside its read loop: between two output bits it injects a new result on the stream port. It then checks the shifted word, the idle level of the data output after the select line rises, and the word returned by the next read.

// File: rtl/sra_pkg.sv
package sra_pkg;
  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_WR   = 2'd1,
    PH_RD   = 2'd2,
    PH_DONE = 2'd3
  } phase_e;
endpackage

// File: rtl/sra_sync.sv
module sra_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[s] <= RST_VAL;
        else if (s == 0) st[s] <= d;
        else st[s] <= st[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q = st[STAGES-1];
endmodule

// File: rtl/sra_frame.sv
module sra_frame
  import sra_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int RES_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sck_s,
  input  logic              sdi_s,
  input  logic [RES_W-1:0]  rd_word,
  output logic              wr_en,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_req,
  output logic              sdo_bit
);
  localparam int HDR_BITS = ADDR_W + 2;
  localparam int CNT_W = $clog2(HDR_BITS + DATA_W + 1);
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] WR_LAST = CNT_W'(HDR_BITS + DATA_W - 1);

  logic             sck_q;
  logic [CNT_W-1:0] cnt;
  logic             start_ok;
  logic             out_en;
  logic [RES_W-1:0] shreg;
  phase_e           phase;

  wire rise = sck_s & ~sck_q;
  wire fall = ~sck_s & sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      cnt      <= '0;
      start_ok <= 1'b0;
      out_en   <= 1'b0;
      shreg    <= '1;
      phase    <= PH_HDR;
      addr     <= '0;
      wr_data  <= '0;
      wr_en    <= 1'b0;
      rd_req   <= 1'b0;
    end else begin
      sck_q  <= sck_s;
      wr_en  <= 1'b0;
      rd_req <= 1'b0;
      if (cs_s) begin
        cnt      <= '0;
        start_ok <= 1'b0;
        out_en   <= 1'b0;
        shreg    <= '1;
        phase    <= PH_HDR;
      end else begin
        if (rise) begin
          if (cnt != '1) cnt <= cnt + 1'b1;
          unique case (phase)
            PH_HDR: begin
              if (cnt == '0) start_ok <= ~sdi_s;
              else if (cnt <= ADDR_LAST) addr <= {addr[ADDR_W-2:0], sdi_s};
              else if (!start_ok) phase <= PH_DONE;
              else if (sdi_s) begin
                phase  <= PH_RD;
                rd_req <= 1'b1;
              end else phase <= PH_WR;
            end
            PH_WR: begin
              wr_data <= {wr_data[DATA_W-2:0], sdi_s};
              if (cnt == WR_LAST) begin
                wr_en <= 1'b1;
                phase <= PH_DONE;
              end
            end
            default: ;
          endcase
        end
        if (rd_req) shreg <= rd_word;
        else if (fall && phase == PH_RD) begin
          if (!out_en) out_en <= 1'b1;
          else shreg <= {shreg[RES_W-2:0], 1'b1};
        end
      end
    end
  end

  assign sdo_bit = out_en ? shreg[RES_W-1] : 1'b1;

  assert_deselect_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> (cnt == '0 && phase == PH_HDR && !out_en));
  assert_read_enters_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !cs_s) |=> (phase == PH_RD && shreg == $past(rd_word)));
  assert_one_command_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, rd_req}));
endmodule

// File: rtl/sra_regfile.sv
module sra_regfile #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int RES_W  = 24
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [ADDR_W-1:0]                   addr,
  input  logic [DATA_W-1:0]                   wr_data,
  input  logic                                rd_req,
  input  logic                                res_valid,
  input  logic [RES_W-1:0]                    res_data,
  output logic [RES_W-1:0]                    rd_word,
  output logic [(DATA_W<<(ADDR_W-1))-1:0]     ctrl_flat,
  output logic                                irq_pending
);
  localparam int IDX_W = ADDR_W - 1;
  localparam int NUM_CTRL = 1 << IDX_W;

  logic [DATA_W-1:0] ctrl_q [NUM_CTRL];
  logic [RES_W-1:0]  result_q;
  wire               res_sel = addr[ADDR_W-1];

  genvar g;
  generate
    for (g = 0; g < NUM_CTRL; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q[g] <= '0;
        else if (wr_en && !res_sel && addr[IDX_W-1:0] == IDX_W'(g)) ctrl_q[g] <= wr_data;
      end
      assign ctrl_flat[g*DATA_W +: DATA_W] = ctrl_q[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result_q    <= '0;
      irq_pending <= 1'b0;
    end else begin
      if (res_valid) result_q <= res_data;
      if (res_valid) irq_pending <= 1'b1;
      else if (rd_req && res_sel) irq_pending <= 1'b0;
    end
  end

  assign rd_word = res_sel ? result_q
                           : {ctrl_q[addr[IDX_W-1:0]], {(RES_W-DATA_W){1'b1}}};

  assert_irq_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> irq_pending);
  assert_irq_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && res_sel && !res_valid) |=> !irq_pending);
  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || res_sel) |=> $stable(ctrl_flat));
  assert_result_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |=> $stable(result_q));
endmodule

// File: rtl/ser_reg_port.sv
module ser_reg_port #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 8,
  parameter int RES_W  = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cs_n,
  input  logic                            sck,
  input  logic                            sdi,
  output logic                            sdo,
  input  logic                            res_valid,
  output logic                            res_ready,
  input  logic [RES_W-1:0]                res_data,
  output logic [(DATA_W<<(ADDR_W-1))-1:0] ctrl_regs
);
  logic [2:0]        pins_s;
  logic              wr_en, rd_req, sdo_bit, irq_pending;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wr_data;
  logic [RES_W-1:0]  rd_word;

  sra_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({cs_n, sck, sdi}), .q(pins_s));

  sra_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs_s(pins_s[2]), .sck_s(pins_s[1]), .sdi_s(pins_s[0]),
    .rd_word(rd_word), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_req(rd_req), .sdo_bit(sdo_bit));

  sra_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_req(rd_req), .res_valid(res_valid), .res_data(res_data),
    .rd_word(rd_word), .ctrl_flat(ctrl_regs), .irq_pending(irq_pending));

  assign res_ready = 1'b1;
  assign sdo = pins_s[2] ? ~irq_pending : sdo_bit;
endmodule

// File: tb/ser_reg_port_tb.sv
`timescale 1ns/1ps
module ser_reg_port_tb;
  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n, cs_n, sck, sdi, res_valid;
  logic [23:0] res_data;
  logic        sdo, res_ready;
  logic [31:0] ctrl_regs;

  typedef struct { int req; logic [31:0] val; } item_t;
  item_t exp_q[$];
  item_t act_q[$];
  int n_run = 0, n_fail = 0;
  logic [23:0] rd;

  always #2.5 clk = ~clk;

  ser_reg_port u_dut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data),
    .ctrl_regs(ctrl_regs));

  task automatic wait_clk(int n); repeat (n) @(negedge clk); endtask

  task automatic expect_val(int req, logic [31:0] v);
    item_t it; it.req = req; it.val = v; exp_q.push_back(it);
  endtask

  task automatic observe(int req, logic [31:0] v);
    item_t it; it.req = req; it.val = v; act_q.push_back(it);
  endtask

  task automatic check(int req, logic [31:0] act, logic [31:0] exp);
    expect_val(req, exp);
    observe(req, act);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      while (exp_q.size() > 0 && act_q.size() > 0) begin
        item_t e, a;
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_run++;
        if (e.val !== a.val) begin
          n_fail++;
          $display("FAIL R%0d: actual %h expected %h", e.req, a.val, e.val);
        end
      end
    end
  end

  task automatic pulse_res(logic [23:0] v);
    @(negedge clk); res_valid = 1'b1; res_data = v;
    @(negedge clk); res_valid = 1'b0;
  endtask

  task automatic put_bit(logic b);
    sdi = b; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
  endtask

  task automatic frame(logic lead, logic [2:0] a, logic dir, logic [7:0] wd, int nwr,
                       int nrd, int inj_at, logic [23:0] inj_val, output logic [23:0] rv);
    cs_n = 1'b0; wait_clk(HALF);
    put_bit(lead);
    for (int i = 2; i >= 0; i--) put_bit(a[i]);
    put_bit(dir);
    for (int i = 0; i < nwr; i++) put_bit(wd[7-i]);
    rv = '0;
    for (int i = 0; i < nrd; i++) begin
      wait_clk(HALF);
      rv = {rv[22:0], sdo};
      if (i == inj_at) pulse_res(inj_val);
      sck = 1'b1; wait_clk(HALF); sck = 1'b0;
    end
    wait_clk(HALF); cs_n = 1'b1; sdi = 1'b0; wait_clk(2*HALF);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    logic [23:0] dummy;
    frame(1'b0, a, 1'b0, d, 8, 0, -1, '0, dummy);
  endtask

  task automatic rd_reg(logic [2:0] a, int n, output logic [23:0] v);
    frame(1'b0, a, 1'b1, 8'h00, 0, n, -1, '0, v);
  endtask

  task automatic finish_run;
    wait_clk(4);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    wait_clk(100000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; sdi = 1'b0; res_valid = 1'b0; res_data = '0;
    wait_clk(5); rst_n = 1'b1; wait_clk(10);
    check(1, ctrl_regs, 32'h0);                  // R1 registers cleared
    check(1, {31'b0, sdo}, 32'h1);               // R1 idle line high
    check(12, {31'b0, res_ready}, 32'h1);        // R12 always ready

    wr(3'd0, 8'hA5); wr(3'd1, 8'h3C); wr(3'd3, 8'hFF);
    check(3, ctrl_regs, 32'hFF00_3CA5);          // R3 byte placement
    rd_reg(3'd1, 8, rd); check(4, {24'b0, rd[7:0]}, 32'h3C);  // R4
    rd_reg(3'd0, 8, rd); check(2, {24'b0, rd[7:0]}, 32'hA5);  // R2 header decode
    rd_reg(3'd3, 8, rd); check(4, {24'b0, rd[7:0]}, 32'hFF);  // R4

    wr(3'd5, 8'h77);
    check(8, ctrl_regs, 32'hFF00_3CA5);          // R8 result address write ignored

    frame(1'b0, 3'd2, 1'b0, 8'hC3, 4, 0, -1, '0, rd);
    check(6, ctrl_regs, 32'hFF00_3CA5);          // R6 aborted write
    wr(3'd2, 8'h81);
    check(6, ctrl_regs, 32'hFF81_3CA5);          // R6 next frame decodes

    frame(1'b1, 3'd2, 1'b0, 8'h11, 8, 0, -1, '0, rd);
    check(7, ctrl_regs, 32'hFF81_3CA5);          // R7 bad leading bit

    pulse_res(24'h123456); wait_clk(6);
    check(9, {31'b0, sdo}, 32'h0);               // R9 flag low
    rd_reg(3'd0, 8, rd); check(4, {24'b0, rd[7:0]}, 32'hA5);
    check(10, {31'b0, sdo}, 32'h0);              // R10 control read keeps flag
    rd_reg(3'd4, 24, rd); check(5, {8'b0, rd}, 32'h123456);  // R5
    check(10, {31'b0, sdo}, 32'h1);              // R10 flag cleared

    pulse_res(24'hABCDEF); wait_clk(4);
    frame(1'b0, 3'd7, 1'b1, 8'h00, 0, 24, 5, 24'h00FF00, rd);
    check(11, {8'b0, rd}, 32'hABCDEF);           // R11 shadowed word
    check(11, {31'b0, sdo}, 32'h0);              // R11 new result pending
    rd_reg(3'd4, 24, rd); check(12, {8'b0, rd}, 32'h00FF00);  // R12

    pulse_res(24'h111111); pulse_res(24'h222222); wait_clk(4);
    rd_reg(3'd6, 24, rd); check(12, {8'b0, rd}, 32'h222222);  // R12 latest wins
    check(10, {31'b0, sdo}, 32'h1);              // R10

    wait_clk(4);
    if (exp_q.size() != 0 || act_q.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size() + act_q.size());
    end
    finish_run();
  end
endmodule